// File: doc/BRIEF.md
# PLL Control Sequencer with Lock Polling

This block owns the control word of one phase-locked loop and runs the steps a host would otherwise perform in software. The host issues a single command to switch the PLL on or off, or to load new divider factors. The block then writes the control word, pulses the PLL reset, and watches the lock indication. It reports either a completion pulse or a timeout pulse.

The PLL output rate is the reference rate divided by the reference divider NR, multiplied by the feedback factor NF, and divided by the output divider OD. Each factor is held in the word as its value minus one. Two reprogramming policies exist. The relock policy loads the factors and then reruns the reset-and-lock sequence while the PLL stays enabled. The gated policy loads the factors and switches the PLL off in the same write, with no reset.

Lock is checked once at the end of each poll interval, and the interval length scales with NR. The lock input is asynchronous, so it passes through a synchronizer before any check. A sequence gives up after a bounded number of intervals.

Top module: `pllseq_top`

## Requirements
- R1: After reset the control word `pll_ctl` is all zero and `cmd_busy`, `seq_done`, `seq_timeout` and `cmd_refused` are low.
- R2: `pll_ctl` holds the following fields:
  - bit 0: enable
  - bit 1: PLL reset
  - bits 7:2: NR-1
  - bits 20:8: NF-1
  - bits 24:21: OD-1
  - bits 29:25: zero
  - bit 30: a registered copy of `bypass_sel`
  - bit 31: the synchronized lock input

  `cmd_op` encodings are 0 enable, 1 disable, 2 relock reprogram and 3 gated reprogram.
- R3: An enable command while the enable bit is already set raises `seq_done` on the first cycle after the command. It produces no reset pulse and changes no field.
- R4: An enable command while the enable bit is clear sets the enable bit on the command cycle. The reset bit is high for exactly one cycle, starting one cycle after the command, and then polling starts.
- R5: The poll interval is POLL_MULT×NR clock cycles, using the stored NR. Counting the command edge as edge 0, `seq_done` is registered at edge 1+k×interval, where k is the first interval whose end sees the synchronized lock high.
- R6: If no interval end sees lock within RETRIES intervals, `seq_timeout` pulses at edge 1+RETRIES×interval and the enable bit keeps its value. `seq_done` and `seq_timeout` never pulse together.
- R7: A disable command clears only the enable bit, keeps NR, NF and OD, and pulses `seq_done` on the next cycle.
- R8: A relock reprogram loads all three factors at once and leaves the enable bit unchanged. It then issues the same one-cycle reset and lock poll as R4 and R5.
- R9: A gated reprogram loads all three factors and clears the enable bit in one write. It issues no reset pulse and pulses `seq_done` on the next cycle.
- R10: While `cmd_busy` is high, a command is not executed. `cmd_refused` pulses on the following cycle and the divider fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is clocked here |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command code (R2) |
| cmd_nr_m1 | input | NR_W | NR minus one for reprogram commands |
| cmd_nf_m1 | input | NF_W | NF minus one for reprogram commands |
| cmd_od_m1 | input | OD_W | OD minus one for reprogram commands |
| bypass_sel | input | 1 | Requested bypass level, mirrored into the word |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_ctl | output | 32 | PLL control word (R2) |
| cmd_busy | output | 1 | A reset-and-poll sequence is in progress |
| cmd_refused | output | 1 | Pulse: the previous cycle's command was dropped |
| seq_done | output | 1 | Pulse: command finished successfully |
| seq_timeout | output | 1 | Pulse: lock not seen within the retry limit |

## Verification
The bench builds the block with POLL_MULT=8 and RETRIES=3, keeping the default field widths. With these values an interval is 8, 16 or 32 cycles for NR of 1, 2 or 4. A lock that arrives in the second interval, and a full timeout after three empty intervals, both finish within a few dozen cycles, so the exact completion edge can be compared in every case. The behavioural PLL model in the bench drops lock during reset, relocks after a chosen delay, and locks at once in bypass. This makes late lock, lock in the first interval and no lock all reachable.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    // Host command codes (R2)
    typedef enum logic [1:0] {
        OP_ENABLE  = 2'd0,
        OP_DISABLE = 2'd1,
        OP_RELOCK  = 2'd2,
        OP_GATED   = 2'd3
    } op_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_POLL  = 2'd2
    } st_e;

endpackage

// File: rtl/pllseq_sync.sv
module pllseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pllseq_poll_timer.sv
module pllseq_poll_timer #(
    parameter int NR_W      = 6,
    parameter int POLL_MULT = 500,
    parameter int BLANK     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic [NR_W-1:0] nr_m1,
    output logic            tick,
    output logic            settled
);
    localparam int IW = $clog2(POLL_MULT * (2 ** NR_W) + 1);
    localparam int BW = $clog2(BLANK + 1);
    localparam logic [IW-1:0] MULT  = IW'(POLL_MULT);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic [IW-1:0] limit;
        logic [BW-1:0] blank;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt   = '0;
            d.limit = (IW'(nr_m1) + IW'(1)) * MULT - IW'(1);
            d.blank = '0;
        end else if (run) begin
            if (q.cnt == q.limit) d.cnt = '0;
            else                  d.cnt = q.cnt + IW'(1);
            if (q.blank != BLANK_END) d.blank = q.blank + BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick    = run && !start && (q.cnt == q.limit);
    assign settled = (q.blank == BLANK_END);
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
#(
    parameter int NR_W    = 6,
    parameter int NF_W    = 13,
    parameter int OD_W    = 4,
    parameter int RETRIES = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [NR_W-1:0] cmd_nr_m1,
    input  logic [NF_W-1:0] cmd_nf_m1,
    input  logic [OD_W-1:0] cmd_od_m1,
    input  logic            bypass_sel,
    input  logic            lock_s,
    input  logic            tick,
    input  logic            settled,
    output logic            en,
    output logic            rst_bit,
    output logic [NR_W-1:0] nr_m1,
    output logic [NF_W-1:0] nf_m1,
    output logic [OD_W-1:0] od_m1,
    output logic            byp,
    output logic            busy,
    output logic            done,
    output logic            tout,
    output logic            refused,
    output logic            timer_start,
    output logic            timer_run
);
    localparam int RW = (RETRIES > 1) ? $clog2(RETRIES) : 1;
    localparam logic [RW-1:0] LAST_TRY = RW'(RETRIES - 1);

    typedef struct packed {
        st_e             st;
        logic            en;
        logic            rst;
        logic [NR_W-1:0] nr;
        logic [NF_W-1:0] nf;
        logic [OD_W-1:0] od;
        logic            byp;
        logic [RW-1:0]   retry;
        logic            done;
        logic            tout;
        logic            refused;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.tout      = 1'b0;
        d.refused   = 1'b0;
        d.rst       = 1'b0;
        d.byp       = bypass_sel;
        timer_start = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_e'(cmd_op))
                        OP_ENABLE: begin
                            if (q.en) begin
                                d.done = 1'b1;
                            end else begin
                                d.en = 1'b1;
                                d.st = ST_RESET;
                            end
                        end
                        OP_DISABLE: begin
                            d.en   = 1'b0;
                            d.done = 1'b1;
                        end
                        OP_RELOCK: begin
                            d.nr = cmd_nr_m1;
                            d.nf = cmd_nf_m1;
                            d.od = cmd_od_m1;
                            d.st = ST_RESET;
                        end
                        OP_GATED: begin
                            d.nr   = cmd_nr_m1;
                            d.nf   = cmd_nf_m1;
                            d.od   = cmd_od_m1;
                            d.en   = 1'b0;
                            d.done = 1'b1;
                        end
                    endcase
                end
            end
            ST_RESET: begin
                d.refused   = cmd_valid;
                d.rst       = 1'b1;
                d.retry     = '0;
                d.st        = ST_POLL;
                timer_start = 1'b1;
            end
            ST_POLL: begin
                d.refused = cmd_valid;
                if (tick) begin
                    if (lock_s && settled) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else if (q.retry == LAST_TRY) begin
                        d.tout = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.retry = q.retry + RW'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en        = q.en;
    assign rst_bit   = q.rst;
    assign nr_m1     = q.nr;
    assign nf_m1     = q.nf;
    assign od_m1     = q.od;
    assign byp       = q.byp;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign tout      = q.tout;
    assign refused   = q.refused;
    assign timer_run = (q.st == ST_POLL);
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top #(
    parameter int NR_W        = 6,
    parameter int NF_W        = 13,
    parameter int OD_W        = 4,
    parameter int POLL_MULT   = 500,
    parameter int RETRIES     = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [NR_W-1:0] cmd_nr_m1,
    input  logic [NF_W-1:0] cmd_nf_m1,
    input  logic [OD_W-1:0] cmd_od_m1,
    input  logic            bypass_sel,
    input  logic            pll_lock,
    output logic [31:0]     pll_ctl,
    output logic            cmd_busy,
    output logic            cmd_refused,
    output logic            seq_done,
    output logic            seq_timeout
);
    localparam int PAD_W = 30 - (2 + NR_W + NF_W + OD_W);
    localparam int BLANK = SYNC_STAGES + 1;

    logic            lock_s, tick, settled, t_start, t_run;
    logic            en, rst_bit, byp;
    logic [NR_W-1:0] nr_m1;
    logic [NF_W-1:0] nf_m1;
    logic [OD_W-1:0] od_m1;

    pllseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pll_lock),
        .dout (lock_s)
    );

    pllseq_poll_timer #(
        .NR_W     (NR_W),
        .POLL_MULT(POLL_MULT),
        .BLANK    (BLANK)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (t_start),
        .run    (t_run),
        .nr_m1  (nr_m1),
        .tick   (tick),
        .settled(settled)
    );

    pllseq_fsm #(
        .NR_W   (NR_W),
        .NF_W   (NF_W),
        .OD_W   (OD_W),
        .RETRIES(RETRIES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_nr_m1  (cmd_nr_m1),
        .cmd_nf_m1  (cmd_nf_m1),
        .cmd_od_m1  (cmd_od_m1),
        .bypass_sel (bypass_sel),
        .lock_s     (lock_s),
        .tick       (tick),
        .settled    (settled),
        .en         (en),
        .rst_bit    (rst_bit),
        .nr_m1      (nr_m1),
        .nf_m1      (nf_m1),
        .od_m1      (od_m1),
        .byp        (byp),
        .busy       (cmd_busy),
        .done       (seq_done),
        .tout       (seq_timeout),
        .refused    (cmd_refused),
        .timer_start(t_start),
        .timer_run  (t_run)
    );

    // R2 word layout
    assign pll_ctl = {lock_s, byp, {PAD_W{1'b0}}, od_m1, nf_m1, nr_m1, rst_bit, en};
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        ctl_en,
    input logic        ctl_rst,
    input logic [22:0] ctl_fields,
    input logic        cmd_busy,
    input logic        cmd_refused,
    input logic        seq_done,
    input logic        seq_timeout
);
    assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> !ctl_rst);

    assert_rst_inside_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |-> cmd_busy);

    assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_timeout));

    assert_timeout_after_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_timeout |-> $past(cmd_busy));

    assert_refuse_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_refused |-> $past(cmd_busy && cmd_valid));

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && $past(cmd_busy)) |-> $stable(ctl_fields));

    assert_gated_no_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rst && $past(ctl_rst, 1) == 1'b0) |-> $past(cmd_busy));

    assert_en_kept_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && $past(cmd_busy)) |-> $stable(ctl_en));
endmodule

bind pllseq_top pllseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .ctl_en     (pll_ctl[0]),
    .ctl_rst    (pll_ctl[1]),
    .ctl_fields (pll_ctl[24:2]),
    .cmd_busy   (cmd_busy),
    .cmd_refused(cmd_refused),
    .seq_done   (seq_done),
    .seq_timeout(seq_timeout)
);

// File: tb/pllseq_top_tb_top.sv
module pllseq_top_tb_top;
    localparam int PM = 8;
    localparam int RT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [5:0]  cmd_nr_m1 = '0;
    logic [12:0] cmd_nf_m1 = '0;
    logic [3:0]  cmd_od_m1 = '0;
    logic        bypass_sel = 1'b0;
    logic        pll_lock;
    logic [31:0] pll_ctl;
    logic        cmd_busy, cmd_refused, seq_done, seq_timeout;

    always #10 clk = ~clk;

    pllseq_top #(.POLL_MULT(PM), .RETRIES(RT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nr_m1(cmd_nr_m1), .cmd_nf_m1(cmd_nf_m1), .cmd_od_m1(cmd_od_m1),
        .bypass_sel(bypass_sel), .pll_lock(pll_lock), .pll_ctl(pll_ctl),
        .cmd_busy(cmd_busy), .cmd_refused(cmd_refused),
        .seq_done(seq_done), .seq_timeout(seq_timeout)
    );

    // Behavioural PLL: loses lock while off or in reset, relocks after model_dly
    // cycles, locks at once in bypass.
    int model_dly = 10;
    int mcnt = 0;
    logic lock_r = 1'b0;
    always @(posedge clk) begin
        if (!rst_n || !pll_ctl[0] || pll_ctl[1]) begin
            mcnt   <= 0;
            lock_r <= 1'b0;
        end else if (pll_ctl[30]) begin
            lock_r <= 1'b1;
        end else begin
            mcnt   <= mcnt + 1;
            lock_r <= (mcnt + 1 >= model_dly);
        end
    end
    assign pll_lock = lock_r;

    int errors = 0;
    int checks = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Issue one command and follow it to completion. n counts negedges after
    // the command edge; intrude_at>0 injects a gated command at that point.
    task automatic run_cmd(input logic [1:0] op, input logic [5:0] nr,
                           input logic [12:0] nf, input logic [3:0] od,
                           input int intrude_at,
                           output int n_end, output bit tout,
                           output int first_rst, output int rst_cnt,
                           output bit busy_seen, output bit refused_seen);
        int n = 0;
        n_end = -1; tout = 0; first_rst = -1; rst_cnt = 0;
        busy_seen = 0; refused_seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_nr_m1 = nr; cmd_nf_m1 = nf; cmd_od_m1 = od;
        @(posedge clk);
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (n == 1) cmd_valid = 1'b0;
            if (pll_ctl[1]) begin
                rst_cnt++;
                if (first_rst < 0) first_rst = n;
            end
            if (intrude_at > 0 && n == intrude_at) begin
                busy_seen = cmd_busy;
                cmd_valid = 1'b1; cmd_op = 2'd3;
                cmd_nr_m1 = 6'd7; cmd_nf_m1 = 13'd1; cmd_od_m1 = 4'd1;
            end
            if (intrude_at > 0 && n == intrude_at + 1) begin
                refused_seen = cmd_refused;
                cmd_valid = 1'b0;
            end
            if (seq_done || seq_timeout) begin
                n_end = n;
                tout  = seq_timeout;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  nr;
        logic [12:0] nf;
        logic [3:0]  od;
        logic [7:0]  dly;
        logic [7:0]  exp_n;
        logic        exp_tout;
        logic        exp_en;
        logic [1:0]  exp_rst;
    } vec_t;

    // exp_n: negedge index of completion (1 = immediate, 2+k*interval after poll)
    localparam vec_t VECS [8] = '{
        '{2'd0, 6'd0, 13'd0,    4'd0,  8'd10,  8'd18, 1'b0, 1'b1, 2'd1}, // R4 R5 lock in 2nd interval of 8
        '{2'd0, 6'd5, 13'd9,    4'd2,  8'd10,  8'd1,  1'b0, 1'b1, 2'd0}, // R3 already on
        '{2'd2, 6'd1, 13'd100,  4'd3,  8'd5,   8'd18, 1'b0, 1'b1, 2'd1}, // R8 relock, interval 16
        '{2'd1, 6'd9, 13'd9,    4'd9,  8'd5,   8'd1,  1'b0, 1'b0, 2'd0}, // R7 disable
        '{2'd3, 6'd3, 13'd7,    4'd1,  8'd5,   8'd1,  1'b0, 1'b0, 2'd0}, // R9 gated
        '{2'd0, 6'd0, 13'd0,    4'd0,  8'd40,  8'd66, 1'b0, 1'b1, 2'd1}, // R5 interval 32, k=2
        '{2'd2, 6'd0, 13'd4095, 4'd15, 8'd200, 8'd26, 1'b1, 1'b1, 2'd1}, // R6 timeout
        '{2'd1, 6'd2, 13'd2,    4'd2,  8'd5,   8'd1,  1'b0, 1'b0, 2'd0}  // R7 disable again
    };

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog (all requirements): actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [5:0]  e_nr;
        logic [12:0] e_nf;
        logic [3:0]  e_od;
        int  n_end, first_rst, rst_cnt;
        bit  tout, busy_seen, refused_seen;

        e_nr = '0; e_nf = '0; e_od = '0;
        repeat (4) @(negedge clk);
        check("R1", "ctl in reset", int'(pll_ctl), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ctl after reset", int'(pll_ctl), 0);
        check("R1", "flags after reset",
              int'({cmd_busy, cmd_refused, seq_done, seq_timeout}), 0);

        foreach (VECS[i]) begin
            model_dly = int'(VECS[i].dly);
            run_cmd(VECS[i].op, VECS[i].nr, VECS[i].nf, VECS[i].od, 0,
                    n_end, tout, first_rst, rst_cnt, busy_seen, refused_seen);
            if (VECS[i].op == 2'd2 || VECS[i].op == 2'd3) begin
                e_nr = VECS[i].nr; e_nf = VECS[i].nf; e_od = VECS[i].od;
            end
            check("R5 R6", $sformatf("vec%0d completion edge", i), n_end, int'(VECS[i].exp_n));
            check("R6", $sformatf("vec%0d timeout flag", i), int'(tout), int'(VECS[i].exp_tout));
            check("R3 R9", $sformatf("vec%0d reset pulses", i), rst_cnt, int'(VECS[i].exp_rst));
            if (VECS[i].exp_rst != 0)
                check("R4", $sformatf("vec%0d reset position", i), first_rst, 2);
            check("R7 R8", $sformatf("vec%0d enable bit", i), int'(pll_ctl[0]), int'(VECS[i].exp_en));
            check("R2 R8", $sformatf("vec%0d fields", i), int'(pll_ctl[24:2]),
                  int'({e_od, e_nf, e_nr}));
        end

        // Bypass mirror and immediate lock (R2); enable from off, interval 8 -> n=10
        bypass_sel = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", "bypass bit", int'(pll_ctl[30]), 1);
        run_cmd(2'd0, 6'd0, 13'd0, 4'd0, 0, n_end, tout, first_rst, rst_cnt, busy_seen, refused_seen);
        check("R5", "bypass lock first interval", n_end, 10);
        check("R2", "lock bit after done", int'(pll_ctl[31]), 1);

        // Busy refusal (R10): relock, gated command injected mid-sequence
        bypass_sel = 1'b0;
        model_dly  = 10;
        repeat (2) @(negedge clk);
        run_cmd(2'd2, 6'd0, 13'd33, 4'd2, 3, n_end, tout, first_rst, rst_cnt, busy_seen, refused_seen);
        e_nr = 6'd0; e_nf = 13'd33; e_od = 4'd2;
        check("R10", "busy mid-sequence", int'(busy_seen), 1);
        check("R10", "refused pulse", int'(refused_seen), 1);
        check("R10", "sequence still completes", n_end, 18);
        check("R10", "fields untouched by refused cmd", int'(pll_ctl[24:2]),
              int'({e_od, e_nf, e_nr}));
        check("R10", "enable untouched by refused cmd", int'(pll_ctl[0]), 1);

        report();
        $finish;
    end
endmodule